// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in memory. A requester presents the virtual address and the physical address of the top-level table. The walker then reads the top-level entry and the leaf entry over a read port. That port issues one request and waits for a response, for as many cycles as the response takes.

When both entries are marked present, the walker returns two things:
- the leaf frame number joined to the untouched page offset;
- the leaf's protection, modified, referenced and no-cache bits.

If either entry is absent, it reports a page fault instead, with the level that failed. It never produces an address in that case.

Each result appears as a single-cycle pulse. The walker takes a new request only while idle.

Top module: `pt_walker`

## Requirements
- R1: The virtual address is split into three fields: top index = bits 31:22, leaf index = bits 21:12, page offset = bits 11:0. For example, 0x00403004 gives top index 1, leaf index 3 and offset 4.
- R2: After a request is accepted, the first read goes to `root_base + top_index*4`. It is issued as a single-cycle `mem_rd_en` pulse in the cycle after acceptance.
- R3: When the top-level entry is present, the second read goes to `{top_entry[31:12], 12'h000} + leaf_index*4`.
- R4: When the leaf entry is present, `done` pulses for exactly one cycle with `paddr = {leaf_entry[31:12], offset}`.
- R5: Entry format: bit 0 = present, bits 2:1 = protection, bit 3 = modified, bit 4 = referenced, bit 5 = no-cache. When `done` is high, `prot`, `modified`, `referenced` and `nocache` show the leaf entry's fields.
- R6: A top-level entry with bit 0 clear makes `fault` pulse for one cycle with `fault_level` = 0. No second read is issued, and `done` does not rise.
- R7: A leaf entry with bit 0 clear makes `fault` pulse for one cycle with `fault_level` = 1. `done` does not rise.
- R8: `ready` is high only while the walker is idle. `req_valid` seen while `ready` is low is ignored and starts no walk and no read.
- R9: `req_vaddr` and `root_base` are captured when the request is accepted. Later changes on those inputs do not affect the walk in progress.
- R10: Each read waits for `mem_rd_valid` for any number of cycles and issues no second request while it waits.
- R11: After reset, `ready` is 1 and `done`, `fault` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when `ready` is high |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical address of the top-level table |
| ready | output | 1 | Walker idle and able to accept a request |
| mem_rd_en | output | 1 | Single-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | Level of the absent entry (0 top, 1 leaf); valid with `fault` |
| paddr | output | 32 | Physical address; valid with `done` |
| prot | output | 2 | Leaf protection field; valid with `done` |
| modified | output | 1 | Leaf modified bit; valid with `done` |
| referenced | output | 1 | Leaf referenced bit; valid with `done` |
| nocache | output | 1 | Leaf no-cache bit; valid with `done` |

## Verification
The bench targets the following corner cases:
- **All-ones address.** Both indices are 1023 and the offset is 0xFFF. A bad shift or index slice would read the wrong entry, and a truncated join would lose offset bits.
- **Absent top-level entry.** A design that still issues the leaf read would show a second address in the read log.
- **Absent leaf entry.** A design that checks only the top level would pulse `done` with a bogus frame.
- **Long memory latency.** A walker that re-issues its request while waiting would log duplicate reads.
- **Request held high through a walk.** A walker that does not gate acceptance on `ready` would start a second walk.
- **Scrambled inputs after acceptance.** A walker that reads its inputs live would return an address built from the scrambled values.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ_L1 = 3'd1,
    ST_READ_L2 = 3'd2,
    ST_DONE    = 3'd3,
    ST_FAULT   = 3'd4
  } walk_state_e;

  // Entry field positions (shared by both table levels)
  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_PROT_LSB    = 1;
  localparam int PTE_PROT_W      = 2;
  localparam int PTE_MOD_BIT     = 3;
  localparam int PTE_REF_BIT     = 4;
  localparam int PTE_NC_BIT      = 5;

  typedef struct packed {
    logic                  nocache;
    logic                  referenced;
    logic                  modified;
    logic [PTE_PROT_W-1:0] prot;
  } pte_attr_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW       = 32,
  parameter int IDX_W    = 10,
  parameter int ESZ_LOG2 = 2
) (
  input  logic [AW-1:0]    tbl_base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    entry_addr
);
  localparam int PAD_W = AW - IDX_W;

  assign entry_addr = tbl_base + ({{PAD_W{1'b0}}, idx} << ESZ_LOG2);

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte,
  output logic                   present,
  output logic [PTE_W-OFF_W-1:0] frame,
  output pte_attr_t              attr
);
  assign present         = pte[PTE_PRESENT_BIT];
  assign frame           = pte[PTE_W-1:OFF_W];
  assign attr.prot       = pte[PTE_PROT_LSB +: PTE_PROT_W];
  assign attr.modified   = pte[PTE_MOD_BIT];
  assign attr.referenced = pte[PTE_REF_BIT];
  assign attr.nocache    = pte[PTE_NC_BIT];
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rsp_valid,
  input  logic        entry_present,
  output walk_state_e state_q,
  output logic        accept,
  output logic        rd_issue,
  output logic        l1_load,
  output logic        leaf_load,
  output logic        fault_load
);
  walk_state_e state_d;
  logic        pending_q, pending_d;
  logic        rsp_take;
  logic        in_read;

  assign in_read  = (state_q == ST_READ_L1) || (state_q == ST_READ_L2);
  assign rd_issue = in_read && !pending_q;
  assign rsp_take = in_read && pending_q && rsp_valid;

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    l1_load    = 1'b0;
    leaf_load  = 1'b0;
    fault_load = 1'b0;
    pending_d  = pending_q;
    if (rd_issue)      pending_d = 1'b1;
    else if (rsp_take) pending_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        if (rsp_take) begin
          if (entry_present) begin
            l1_load = 1'b1;
            state_d = ST_READ_L2;
          end else begin
            fault_load = 1'b1;
            state_d    = ST_FAULT;
          end
        end
      end
      ST_READ_L2: begin
        if (rsp_take) begin
          if (entry_present) begin
            leaf_load = 1'b1;
            state_d   = ST_DONE;
          end else begin
            fault_load = 1'b1;
            state_d    = ST_FAULT;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pending_q <= pending_d;
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 12,
  parameter int ESZ_LOG2 = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [VA_W-1:0] root_base,
  output logic            ready,
  output logic            mem_rd_en,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [VA_W-1:0] mem_rd_data,
  output logic            done,
  output logic            fault,
  output logic            fault_level,
  output logic [VA_W-1:0] paddr,
  output logic [1:0]      prot,
  output logic            modified,
  output logic            referenced,
  output logic            nocache
);
  localparam int LEVELS  = 2;
  localparam int FRAME_W = VA_W - OFF_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  walk_state_e state_q;
  logic        accept, rd_issue, l1_load, leaf_load, fault_load;
  logic        ent_present;
  logic [FRAME_W-1:0] ent_frame;
  pte_attr_t   ent_attr;

  ptw_pte_decode #(.PTE_W(VA_W), .OFF_W(OFF_W)) u_dec (
    .pte     (mem_rd_data),
    .present (ent_present),
    .frame   (ent_frame),
    .attr    (ent_attr)
  );

  ptw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .rsp_valid     (mem_rd_valid),
    .entry_present (ent_present),
    .state_q       (state_q),
    .accept        (accept),
    .rd_issue      (rd_issue),
    .l1_load       (l1_load),
    .leaf_load     (leaf_load),
    .fault_load    (fault_load)
  );

  // Walk context, each register with its own load enable
  logic [VA_W-1:0] va_q, base_q, l2_base_q, pa_q;
  pte_attr_t       attr_q;
  logic            flvl_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      va_q      <= '0;
      base_q    <= '0;
      l2_base_q <= '0;
      pa_q      <= '0;
      attr_q    <= '0;
      flvl_q    <= 1'b0;
    end else begin
      if (accept) begin
        va_q   <= req_vaddr;
        base_q <= root_base;
      end
      if (l1_load) l2_base_q <= {ent_frame, {OFF_W{1'b0}}};
      if (leaf_load) begin
        pa_q   <= {ent_frame, va_q[OFF_W-1:0]};
        attr_q <= ent_attr;
      end
      if (fault_load) flvl_q <= (state_q == ST_READ_L2);
    end
  end

  // Per-level entry address generation
  logic [VA_W-1:0]  lvl_base [LEVELS];
  logic [IDX_W-1:0] lvl_idx  [LEVELS];
  logic [VA_W-1:0]  lvl_addr [LEVELS];

  assign lvl_base[0] = base_q;
  assign lvl_base[1] = l2_base_q;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign lvl_idx[g] = va_q[OFF_W + IDX_W*(LEVELS-g) - 1 -: IDX_W];
    ptw_addr_gen #(.AW(VA_W), .IDX_W(IDX_W), .ESZ_LOG2(ESZ_LOG2)) u_ag (
      .tbl_base   (lvl_base[g]),
      .idx        (lvl_idx[g]),
      .entry_addr (lvl_addr[g])
    );
  end

  assign mem_rd_en   = rd_issue;
  assign mem_rd_addr = (state_q == ST_READ_L2) ? lvl_addr[1] : lvl_addr[0];
  assign ready       = (state_q == ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign fault       = (state_q == ST_FAULT);
  assign fault_level = flvl_q;
  assign paddr       = pa_q;
  assign prot        = attr_q.prot;
  assign modified    = attr_q.modified;
  assign referenced  = attr_q.referenced;
  assign nocache     = attr_q.nocache;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic ready,
  input logic mem_rd_en,
  input logic mem_rd_valid,
  input logic done,
  input logic fault
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  assert_done_xor_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_single_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_accept_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> (!ready && mem_rd_en));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_rd_en);

  assert_end_follows_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> $past(mem_rd_valid));
endmodule

bind pt_walker ptw_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .ready        (ready),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_valid (mem_rd_valid),
  .done         (done),
  .fault        (fault)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        ready, mem_rd_en, done, fault, fault_level;
  logic [31:0] mem_rd_addr, paddr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic [1:0]  prot;
  logic        modified, referenced, nocache;

  always #2 clk = ~clk; // 250 MHz

  pt_walker dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model with programmable latency
  logic [31:0] mem [logic [31:0]];
  int          mem_lat = 1;
  int          lat_cnt = 0;
  logic [31:0] lat_addr;
  logic [31:0] rd_log [$];

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mrd(lat_addr);
      end
    end
    if (rst_n && mem_rd_en) begin
      lat_addr = mem_rd_addr;
      lat_cnt  = mem_lat;
      rd_log.push_back(mem_rd_addr);
    end
  end

  // Behavioural reference model, stepped on every rising edge
  int          m_st = 0;   // 0 idle, 1 top read, 2 leaf read, 3 done, 4 fault
  bit          m_pend = 0, m_lvl = 0;
  logic [31:0] m_va = 0, m_base = 0, m_l2 = 0, m_pa = 0;
  logic [4:0]  m_attr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0;
    end else begin
      case (m_st)
        0: if (req_valid) begin
             m_st = 1; m_va = req_vaddr; m_base = root_base; m_pend = 0;
           end
        1, 2: begin
          if (!m_pend) m_pend = 1;
          else if (mem_rd_valid) begin
            m_pend = 0;
            if (!mem_rd_data[0]) begin
              m_lvl = (m_st == 2);
              m_st  = 4;
            end else if (m_st == 1) begin
              m_l2 = mem_rd_data & 32'hFFFF_F000;
              m_st = 2;
            end else begin
              m_pa   = (mem_rd_data & 32'hFFFF_F000) | (m_va & 32'h0000_0FFF);
              m_attr = mem_rd_data[5:1];
              m_st   = 3;
            end
          end
        end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8", "ready", ready, m_st == 0);
      chk("R10", "rd_en", mem_rd_en, (m_st == 1 || m_st == 2) && !m_pend);
      if (mem_rd_en && m_st == 1)
        chk("R2", "top addr", mem_rd_addr, m_base + ((m_va >> 22) << 2));
      if (mem_rd_en && m_st == 2)
        chk("R3", "leaf addr", mem_rd_addr, m_l2 + (((m_va >> 12) & 32'h3FF) << 2));
      chk("R4", "done", done, m_st == 3);
      chk("R6", "fault", fault, m_st == 4);
      if (done) begin
        chk("R4", "paddr", paddr, m_pa);
        chk("R5", "attr", {nocache, referenced, modified, prot}, m_attr);
      end
      if (fault) chk("R7", "fault_level", fault_level, m_lvl);
    end
  end

  // Directed walk driver
  logic        r_done, r_fault, r_lvl;
  logic [31:0] r_pa;
  logic [4:0]  r_attr;

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input bit hold, input bit scramble);
    int guard = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    rd_log.delete();
    req_valid = 1'b1; req_vaddr = va; root_base = base;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    else req_vaddr = va ^ 32'h0040_0000;
    if (scramble) begin
      req_vaddr = ~va; root_base = base + 32'h100;
    end
    while (!(done || fault) && guard < 1000) begin
      @(negedge clk); guard++;
    end
    r_done = done; r_fault = fault; r_lvl = fault_level; r_pa = paddr;
    r_attr = {nocache, referenced, modified, prot};
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [31:0] BASE = 32'h0001_0000;

  initial begin
    // Tables: top entry 1 -> leaf table 0x20000, top entry 1023 -> 0x30000
    mem[BASE + 32'h4]         = 32'h0002_0001;
    mem[32'h0002_000C]        = 32'h1234_501D; // prot=2, mod, ref, present
    mem[32'h0002_001C]        = 32'h1234_5000; // leaf absent
    mem[BASE + 32'hFFC]       = 32'h0003_0001;
    mem[32'h0003_0FFC]        = 32'hABCD_E021; // nocache, present
    mem[BASE + 32'h8]         = 32'h0004_0001;
    mem[32'h0004_0000]        = 32'h5555_5003; // prot=1, present

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11", "ready after reset", ready, 1);
    chk("R11", "done after reset", done, 0);
    chk("R11", "fault after reset", fault, 0);
    chk("R11", "rd_en after reset", mem_rd_en, 0);

    // R1 worked example, single-cycle latency
    walk(32'h0040_3004, BASE, 0, 0);
    chk("R1", "read count", rd_log.size(), 2);
    chk("R1", "top addr idx1=1", rd_log[0], 32'h0001_0004);
    chk("R1", "leaf addr idx2=3", rd_log[1], 32'h0002_000C);
    chk("R4", "done seen", r_done, 1);
    chk("R4", "paddr offset 4", r_pa, 32'h1234_5004);
    chk("R5", "attr fields", r_attr, 5'b01110);

    // R6 absent top-level entry
    walk(32'h0140_0010, BASE, 0, 0);
    chk("R6", "fault seen", r_fault, 1);
    chk("R6", "fault level 0", r_lvl, 0);
    chk("R6", "no leaf read", rd_log.size(), 1);
    chk("R6", "no done", r_done, 0);

    // R7 absent leaf entry
    walk(32'h0040_7ABC, BASE, 0, 0);
    chk("R7", "fault seen", r_fault, 1);
    chk("R7", "fault level 1", r_lvl, 1);
    chk("R7", "two reads", rd_log.size(), 2);
    chk("R7", "no done", r_done, 0);

    // R1 all-ones indices and offset
    walk(32'hFFFF_FFFF, BASE, 0, 0);
    chk("R1", "top addr idx1=1023", rd_log[0], BASE + 32'hFFC);
    chk("R1", "leaf addr idx2=1023", rd_log[1], 32'h0003_0FFC);
    chk("R4", "paddr all ones offset", r_pa, 32'hABCD_EFFF);
    chk("R5", "nocache attr", r_attr, 5'b10000);

    // R10 long latency
    mem_lat = 5;
    walk(32'h0040_3004, BASE, 0, 0);
    chk("R10", "single read per level", rd_log.size(), 2);
    chk("R10", "paddr slow memory", r_pa, 32'h1234_5004);
    mem_lat = 2;

    // R8 request held high through the walk
    walk(32'h0040_3004, BASE, 1, 0);
    chk("R8", "reads while busy", rd_log.size(), 2);
    chk("R8", "paddr unaffected", r_pa, 32'h1234_5004);
    repeat (4) @(negedge clk);
    chk("R8", "no extra walk", rd_log.size(), 2);
    chk("R8", "ready idle", ready, 1);

    // R9 inputs scrambled after acceptance
    walk(32'h0080_0123, BASE, 0, 1);
    chk("R9", "top addr from latched base", rd_log[0], BASE + 32'h8);
    chk("R9", "paddr from latched va", r_pa, 32'h5555_5123);
    chk("R5", "prot=1 attr", r_attr, 5'b00001);

    // Back-to-back walks at latency 3
    mem_lat = 3;
    walk(32'h0040_3FFF, BASE, 0, 0);
    chk("R4", "paddr back-to-back", r_pa, 32'h1234_5FFF);
    walk(32'h0040_7000, BASE, 0, 0);
    chk("R7", "leaf fault back-to-back", r_fault, 1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule